// File: doc/BRIEF.md
# Packed Pairwise Horizontal Add/Subtract Unit

This block is a SIMD datapath that reduces each of two packed vector operands by combining neighbouring elements. Inside operand A, element 0 is paired with element 1, element 2 with element 3, and so on. Each pair produces one result, and the same pairing is applied to operand B. The results from A fill the lower half of the output vector in ascending order. The results from B fill the upper half in the same order. Lanes may be 16 or 32 bits wide, and the operation may be addition or subtraction. For 16-bit lanes there is also a signed-saturating mode.

The vector width is a parameter that may be 64 or 128 bits. A request is presented with a valid strobe and three mode bits. The result appears one clock later in a registered output stage, together with a valid flag and an error flag. The error flag marks the one mode combination that is not defined: saturation requested with 32-bit lanes.

Top module: `hpair_unit`

## Requirements
- R1: With `mode_sub`=0 and `mode_dword`=0, output 16-bit lane k (bits 16k+15:16k) for k < VEC_W/32 equals A lane 2k plus A lane 2k+1. For k ≥ VEC_W/32, with j = k − VEC_W/32, it equals B lane 2j plus B lane 2j+1.
- R2: With `mode_sub`=1, every result is the even-indexed element minus the odd-indexed element of its pair (lane 2j minus lane 2j+1).
- R3: With `mode_dword`=1, the same pairing and the A-low/B-high packing apply to 32-bit lanes, for both add and subtract.
- R4: With `mode_sat`=0, every result wraps modulo 2 to the power of the lane width. For example, 16'h7FFF + 16'h0001 gives 16'h8000.
- R5: With `mode_sat`=1 and `mode_dword`=0, each 16-bit result is clamped to the signed range. Results above 32767 give 16'h7FFF, and results below −32768 give 16'h8000.
- R6: A valid request with `mode_sat`=1 and `mode_dword`=1 produces an all-zero `res_data` and `res_err`=1 in the result cycle. Every other valid request gives `res_err`=0.
- R7: `res_valid` is `in_valid` delayed by exactly one clock, and `res_data` carries the result of the request accepted on the previous edge.
- R8: When `in_valid` is 0, the operand and mode inputs are ignored. `res_data` keeps its previous value and `res_err` is 0.
- R9: While `rst` is high, `res_valid`, `res_err` and `res_data` are all 0 on the following edge.
- R10: The same behaviour holds for VEC_W = 64, with half as many results per operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opnd_a | input | VEC_W | Operand A; its pair results go to the low half |
| opnd_b | input | VEC_W | Operand B; its pair results go to the high half |
| mode_sub | input | 1 | 1 = even minus odd, 0 = sum |
| mode_dword | input | 1 | 1 = 32-bit lanes, 0 = 16-bit lanes |
| mode_sat | input | 1 | 1 = signed saturation (16-bit lanes only) |
| res_valid | output | 1 | Result valid, one cycle after in_valid |
| res_data | output | VEC_W | Packed pairwise results |
| res_err | output | 1 | Illegal mode combination flagged |

## Verification
An internal fault in the pairing or the half selection shows up at the port as a lane value in the wrong position, or as a value built from the wrong neighbours. It appears on the very next edge after the request. A wrong carry or clamp decision shows only at the extreme operand values, so the vectors place sums and differences right at ±32767 and ±2^31. A fault in the output register shows up as a missing or extra `res_valid` pulse, as a `res_err` that lingers, or as a `res_data` that changes while no request is present. Each of these can be seen within one cycle.

// File: rtl/hpair_pkg.sv
package hpair_pkg;

  // lane size selector values
  typedef enum logic {
    LANE_W16 = 1'b0,
    LANE_W32 = 1'b1
  } lane_sel_e;

  // a request with saturation and 32-bit lanes is undefined
  function automatic logic illegal_mode(input logic sat, input lane_sel_e lsel);
    return sat && (lsel == LANE_W32);
  endfunction

endpackage

// File: rtl/hpair_lane_combiner.sv
module hpair_lane_combiner #(
  parameter int VEC_W   = 128,
  parameter int LANE_W  = 16,
  parameter bit SAT_CAP = 1'b0
) (
  input  logic [VEC_W-1:0] vec_a,
  input  logic [VEC_W-1:0] vec_b,
  input  logic             do_sub,
  input  logic             do_sat,
  output logic [VEC_W-1:0] packed_res
);

  localparam int N_LANES = VEC_W / LANE_W;
  localparam int HALF    = N_LANES / 2;
  localparam logic [LANE_W-1:0] POS_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] NEG_MIN = {1'b1, {(LANE_W-1){1'b0}}};

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    localparam bit FROM_A = (k < HALF);
    localparam int PJ     = FROM_A ? k : k - HALF;

    logic [VEC_W-1:0]         src;
    logic signed [LANE_W:0]   even_x;
    logic signed [LANE_W:0]   odd_x;
    logic signed [LANE_W:0]   full;
    logic                     ovf;

    assign src    = FROM_A ? vec_a : vec_b;
    assign even_x = {src[(2*PJ)*LANE_W + LANE_W-1], src[(2*PJ)*LANE_W +: LANE_W]};
    assign odd_x  = {src[(2*PJ+1)*LANE_W + LANE_W-1], src[(2*PJ+1)*LANE_W +: LANE_W]};
    assign full   = do_sub ? (even_x - odd_x) : (even_x + odd_x);
    assign ovf    = full[LANE_W] ^ full[LANE_W-1];

    if (SAT_CAP) begin : g_sat
      always_comb begin
        if (do_sat && ovf)
          packed_res[k*LANE_W +: LANE_W] = full[LANE_W] ? NEG_MIN : POS_MAX;
        else
          packed_res[k*LANE_W +: LANE_W] = full[LANE_W-1:0];
      end
    end else begin : g_wrap
      logic unused_ok;
      assign unused_ok = do_sat ^ ovf;
      assign packed_res[k*LANE_W +: LANE_W] = full[LANE_W-1:0];
    end
  end

endmodule

// File: rtl/hpair_out_stage.sv
module hpair_out_stage #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nxt_valid,
  input  logic [VEC_W-1:0] nxt_data,
  input  logic             nxt_err,
  output logic             q_valid,
  output logic [VEC_W-1:0] q_data,
  output logic             q_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_err   <= 1'b0;
    end else begin
      q_valid <= nxt_valid;
      q_err   <= nxt_valid && nxt_err;
      if (nxt_valid) q_data <= nxt_data;
    end
  end

  // R7
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (q_valid == $past(nxt_valid)));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(nxt_valid)) |-> ($stable(q_data) && !q_err));

endmodule

// File: rtl/hpair_unit.sv
module hpair_unit #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] opnd_a,
  input  logic [VEC_W-1:0] opnd_b,
  input  logic             mode_sub,
  input  logic             mode_dword,
  input  logic             mode_sat,
  output logic             res_valid,
  output logic [VEC_W-1:0] res_data,
  output logic             res_err
);
  import hpair_pkg::*;

  localparam int W16 = 16;
  localparam int W32 = 32;

  initial begin
    assert (VEC_W == 64 || VEC_W == 128);
  end

  lane_sel_e        lsel;
  logic [VEC_W-1:0] res16;
  logic [VEC_W-1:0] res32;
  logic [VEC_W-1:0] nxt_data;
  logic             bad_mode;

  assign lsel     = mode_dword ? LANE_W32 : LANE_W16;
  assign bad_mode = illegal_mode(mode_sat, lsel);

  hpair_lane_combiner #(.VEC_W(VEC_W), .LANE_W(W16), .SAT_CAP(1'b1)) u_word (
    .vec_a(opnd_a), .vec_b(opnd_b), .do_sub(mode_sub), .do_sat(mode_sat),
    .packed_res(res16)
  );

  hpair_lane_combiner #(.VEC_W(VEC_W), .LANE_W(W32), .SAT_CAP(1'b0)) u_dword (
    .vec_a(opnd_a), .vec_b(opnd_b), .do_sub(mode_sub), .do_sat(1'b0),
    .packed_res(res32)
  );

  always_comb begin
    if (bad_mode)             nxt_data = '0;
    else if (lsel == LANE_W32) nxt_data = res32;
    else                      nxt_data = res16;
  end

  hpair_out_stage #(.VEC_W(VEC_W)) u_out (
    .clk(clk), .rst(rst),
    .nxt_valid(in_valid), .nxt_data(nxt_data), .nxt_err(bad_mode),
    .q_valid(res_valid), .q_data(res_data), .q_err(res_err)
  );

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    res_err |-> (res_data == '0));

  // R6
  err_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    res_err |-> res_valid);

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> (res_err == ($past(mode_sat) && $past(mode_dword))));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && !res_err && res_data == '0));

endmodule

// File: tb/tb_hpair_unit.sv
module tb_hpair_unit;

  typedef struct packed {
    logic [127:0] a;
    logic [127:0] b;
    logic         sub;
    logic         dw;
    logic         sat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TABLE [NV] = '{
    // R1 plain word add
    '{128'h0008_0007_0006_0005_0004_0003_0002_0001, 128'h0010_0020_0030_0040_0050_0060_0070_0080, 1'b0, 1'b0, 1'b0},
    // R2 word subtract, even minus odd
    '{128'h0001_0009_0003_0005_0000_0004_0002_000A, 128'hFFFF_0001_0002_0001_8000_0001_7FFF_0003, 1'b1, 1'b0, 1'b0},
    // R4 word wrap on overflow
    '{128'h0001_7FFF_8000_8000_FFFF_8000_0001_7FFF, 128'h7FFF_7FFF_8000_0001_0002_0003_FFFE_FFFF, 1'b0, 1'b0, 1'b0},
    // R5 saturating add, both ends
    '{128'h0001_7FFF_8000_8000_FFFF_8000_0001_7FFF, 128'h7FFF_7FFF_8000_0001_0002_0003_FFFE_FFFF, 1'b0, 1'b0, 1'b1},
    // R5 saturating subtract, both ends
    '{128'h0001_8000_8000_7FFF_FFFF_7FFF_7FFF_FFFF, 128'h0005_0003_8000_0000_0001_8000_0000_7FFF, 1'b1, 1'b0, 1'b1},
    // R3 dword add with wrap
    '{128'h0000_0001_7FFF_FFFF_1234_5678_0000_0001, 128'hFFFF_FFFF_FFFF_FFFF_8000_0000_8000_0000, 1'b0, 1'b1, 1'b0},
    // R3 dword subtract
    '{128'h0000_0001_8000_0000_0000_0005_0000_0003, 128'h0000_0010_0000_0001_FFFF_FFFF_0000_0000, 1'b1, 1'b1, 1'b0},
    // R6 illegal saturation with dword lanes
    '{128'h1111_2222_3333_4444_5555_6666_7777_8888, 128'h9999_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0001, 1'b0, 1'b1, 1'b1},
    // R5 saturation requested but no overflow
    '{128'h0010_0020_FFF0_0005_0100_0200_0003_0004, 128'hFFFF_FFFF_0001_0001_1000_2000_4000_3FFF, 1'b0, 1'b0, 1'b1},
    // R2 dword-size pattern in word mode
    '{128'h8000_0000_7FFF_FFFF_0000_0001_FFFF_0000, 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10, 1'b1, 1'b0, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] opnd_a = '0;
  logic [127:0] opnd_b = '0;
  logic         mode_sub = 1'b0;
  logic         mode_dword = 1'b0;
  logic         mode_sat = 1'b0;
  logic         res_valid, res_err, n_valid, n_err;
  logic [127:0] res_data;
  logic [63:0]  n_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hpair_unit #(.VEC_W(128)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .mode_sub(mode_sub), .mode_dword(mode_dword), .mode_sat(mode_sat),
    .res_valid(res_valid), .res_data(res_data), .res_err(res_err)
  );

  hpair_unit #(.VEC_W(64)) dut_narrow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a[63:0]), .opnd_b(opnd_b[63:0]),
    .mode_sub(mode_sub), .mode_dword(mode_dword), .mode_sat(mode_sat),
    .res_valid(n_valid), .res_data(n_data), .res_err(n_err)
  );

  function automatic logic [127:0] ref_f(input logic [127:0] a, input logic [127:0] b,
                                         input logic sub, input logic dw, input logic sat,
                                         input int w);
    logic [127:0] r = '0;
    int lw = dw ? 32 : 16;
    int n = w / lw;
    if (sat && dw) return '0;
    for (int k = 0; k < n; k++) begin
      logic [127:0] src = (k < n/2) ? a : b;
      int j = (k < n/2) ? k : k - n/2;
      longint e0, e1, s;
      if (dw) begin
        e0 = longint'($signed(src[2*j*32 +: 32]));
        e1 = longint'($signed(src[(2*j+1)*32 +: 32]));
      end else begin
        e0 = longint'($signed(src[2*j*16 +: 16]));
        e1 = longint'($signed(src[(2*j+1)*16 +: 16]));
      end
      s = sub ? e0 - e1 : e0 + e1;
      if (sat) begin
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
      end
      if (dw) r[k*32 +: 32] = s[31:0];
      else    r[k*16 +: 16] = s[15:0];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input vec_t t);
    in_valid   = v;
    opnd_a     = t.a;
    opnd_b     = t.b;
    mode_sub   = t.sub;
    mode_dword = t.dw;
    mode_sat   = t.sat;
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    vec_t t;
    logic [127:0] prev;
    // R9 reset values, with a request pending during reset
    drive(1'b1, TABLE[0]);
    repeat (3) @(negedge clk);
    check("R9 valid", {127'b0, res_valid}, 128'd0);
    check("R9 err", {127'b0, res_err}, 128'd0);
    check("R9 data", res_data, 128'd0);
    drive(1'b0, TABLE[0]);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 idle valid", {127'b0, res_valid}, 128'd0);

    // table walk, 128-bit and 64-bit instances
    for (int i = 0; i < NV; i++) begin
      t = TABLE[i];
      drive(1'b1, t);
      @(negedge clk);
      check("R1-table data", res_data, ref_f(t.a, t.b, t.sub, t.dw, t.sat, 128));
      check("R7 valid", {127'b0, res_valid}, 128'd1);
      check("R6 err", {127'b0, res_err}, {127'b0, t.sat & t.dw});
      check("R10 narrow data", {64'b0, n_data}, ref_f(t.a, t.b, t.sub, t.dw, t.sat, 64));
      check("R10 narrow err", {127'b0, n_err}, {127'b0, t.sat & t.dw});
    end

    // R4 directed wrap: lane 0 of output = 7FFF + 0001
    t = '{128'h0000_0000_0000_0000_0000_0000_0001_7FFF, 128'h0, 1'b0, 1'b0, 1'b0};
    drive(1'b1, t);
    @(negedge clk);
    check("R4 wrap", {112'b0, res_data[15:0]}, 128'h8000);
    // R5 directed clamp of the same pair
    t.sat = 1'b1;
    drive(1'b1, t);
    @(negedge clk);
    check("R5 clamp", {112'b0, res_data[15:0]}, 128'h7FFF);
    // R2 order: 0003 - 000A in lane 0, B pair in upper half lane 4
    t = '{128'h0000_0000_0000_0000_0000_0000_000A_0003, 128'h0000_0000_0000_0000_0000_0000_0001_0009, 1'b1, 1'b0, 1'b0};
    drive(1'b1, t);
    @(negedge clk);
    check("R2 a-lane", {112'b0, res_data[15:0]}, 128'hFFF9);
    check("R2 b-lane", {112'b0, res_data[79:64]}, 128'h0008);

    // R8 idle: inputs change but result holds and err clears
    prev = res_data;
    t = TABLE[7];
    drive(1'b0, t);
    @(negedge clk);
    check("R8 hold data", res_data, prev);
    check("R8 valid low", {127'b0, res_valid}, 128'd0);
    check("R8 err low", {127'b0, res_err}, 128'd0);
    t = TABLE[3];
    drive(1'b0, t);
    @(negedge clk);
    check("R8 hold data 2", res_data, prev);

    // R6 error clears on the next legal request
    drive(1'b1, TABLE[7]);
    @(negedge clk);
    check("R6 err set", {127'b0, res_err}, 128'd1);
    drive(1'b1, TABLE[0]);
    @(negedge clk);
    check("R6 err clear", {127'b0, res_err}, 128'd0);
    check("R1 after err", res_data, ref_f(TABLE[0].a, TABLE[0].b, 1'b0, 1'b0, 1'b0, 128));

    // R9 reset in mid-stream
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid reset data", res_data, 128'd0);
    check("R9 mid reset valid", {127'b0, res_valid}, 128'd0);
    rst = 1'b0;
    drive(1'b0, TABLE[0]);
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule